// File: doc/BRIEF.md
# Binary-Tree Lookup Accumulator

This block adds up a bounded burst of quantized values without any adder. Each term arrives as a small codebook index. The block combines neighbouring terms pairwise in a binary tree. Every addition is a read from a lookup table. Each tree level has its own table and its own output codebook, so the index width can grow by a fixed step at each level as the range of the partial sums widens. A burst of up to `N_TERMS` indices reduces to one index in the root codebook. The result is presented on a valid/ready output, and a done pulse marks its arrival.

Software, or a training flow, fills the tables through a plain write port before bursts are streamed in. Index 0 in every codebook stands for the value zero. A term left without a partner at some level is therefore looked up against index 0, which passes it up the tree. Every level works on one pair per clock, so terms can stream in back to back. A burst ends on `in_last`, or when its `N_TERMS`-th term is taken, whichever comes first.

Back-pressure rules: an input term is transferred on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` never depends on `in_valid`. A result is transferred when `res_valid` and `res_ready` are both high. While `res_valid` is high and `res_ready` is low, the result holds steady. Stalls propagate down the tree to `in_ready`.

Top module: `tree_lut_accum`

## Requirements
- R1: After reset, `res_valid` and `done` are low and `in_ready` is high.
- R2: A write with `tbl_we` high stores the low W(k+1) bits of `tbl_data` into the table of level k = `tbl_level`, at the address given by the low 2·W(k) bits of `tbl_addr`, where W(k) = `W_IN` + k·`W_GROW`. The address is {first operand, second operand}, and the first operand is the earlier one in arrival order. The stored entry is used by every later lookup at that address.
- R3: At each level, consecutive values are paired in arrival order, and the pair (a, b) produces table entry {a, b} of that level.
- R4: A value left unpaired at the end of a burst at any level produces the table entry {a, 0} of that level.
- R5: A burst closes on the term carrying `in_last`, or on its `N_TERMS`-th term if no `in_last` came earlier. A later term starts a new burst.
- R6: Each burst yields exactly one result, equal to the tree reduction of its terms, and results leave in burst order.
- R7: `done` is high for one cycle each time a fresh result is loaded into the output, and `res_valid` is high whenever `done` is.
- R8: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_idx` holds its value, and no result is dropped.
- R9: While `res_ready` is high, `in_ready` is high, so one term per clock can enter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_level | input | LVL_W | Tree level whose table is written |
| tbl_addr | input | 2·W(LEVELS-1) | Table address {first, second} |
| tbl_data | input | W_OUT | Entry value (low bits used) |
| in_valid | input | 1 | Input term valid |
| in_ready | output | 1 | Block can take a term |
| in_idx | input | W_IN | Input term codebook index |
| in_last | input | 1 | Term closes the burst |
| res_valid | output | 1 | Root result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_idx | output | W_OUT | Root codebook index |
| done | output | 1 | One-cycle pulse on a fresh result |

## Verification
The bench goes after odd burst lengths (1, 3, 5, 7). A design that pairs a leftover with the wrong neighbour, or drops it, returns a wrong root or no root at all. A burst of ten terms with no early `in_last` checks the truncation at `N_TERMS`. Without it there would be two outputs where one is due, or the remainder would merge into the wrong burst. Random back-pressure on the result side catches a result that changes or vanishes while stalled. A rewrite of one table entry between bursts, followed by a burst that reads it, catches swapped operand order or a stale copy of the entry.

// File: rtl/tla_pkg.sv
package tla_pkg;

  // Index width entering tree level k.
  function automatic int lvl_width(input int w_in, input int w_grow, input int k);
    return w_in + k * w_grow;
  endfunction

  // Number of tree levels for a burst limit n (power of two).
  function automatic int lvl_count(input int n);
    return $clog2(n);
  endfunction

endpackage

// File: rtl/tla_table.sv
module tla_table #(
  parameter int AW = 6,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/tla_burst.sv
module tla_burst #(
  parameter int N_TERMS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic in_last,
  output logic eff_last
);
  localparam int CW = (N_TERMS > 2) ? $clog2(N_TERMS) : 1;

  logic [CW-1:0] cnt_q;

  assign eff_last = in_last || (cnt_q == CW'(N_TERMS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (take) begin
      if (eff_last)      cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_BURST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cnt_q == CW'(N_TERMS - 1)) |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/tla_stage.sv
module tla_stage #(
  parameter int WI = 3,
  parameter int WO = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tbl_we,
  input  logic [2*WI-1:0] tbl_addr,
  input  logic [WO-1:0]   tbl_data,
  input  logic            i_valid,
  output logic            i_ready,
  input  logic [WI-1:0]   i_idx,
  input  logic            i_last,
  output logic            o_valid,
  input  logic            o_ready,
  output logic [WO-1:0]   o_idx,
  output logic            o_last,
  output logic            o_load
);
  localparam int AW = 2 * WI;

  logic [WI-1:0] pend_q;
  logic          pend_v_q;
  logic          ov_q, olast_q, load_q;
  logic [WO-1:0] oidx_q;
  logic [AW-1:0] rd_addr;
  logic [WO-1:0] rd_data;
  logic          take, emit;

  assign i_ready = !ov_q || o_ready;
  assign take    = i_valid && i_ready;
  assign emit    = take && (pend_v_q || i_last);
  assign rd_addr = pend_v_q ? {pend_q, i_idx} : {i_idx, {WI{1'b0}}};

  tla_table #(.AW(AW), .DW(WO)) u_tbl (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v_q <= 1'b0;
      pend_q   <= '0;
    end else if (take) begin
      if (emit) pend_v_q <= 1'b0;
      else begin
        pend_v_q <= 1'b1;
        pend_q   <= i_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q    <= 1'b0;
      oidx_q  <= '0;
      olast_q <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      load_q <= emit;
      if (emit) begin
        ov_q    <= 1'b1;
        oidx_q  <= rd_data;
        olast_q <= i_last;
      end else if (o_ready) begin
        ov_q <= 1'b0;
      end
    end
  end

  assign o_valid = ov_q;
  assign o_idx   = oidx_q;
  assign o_last  = olast_q;
  assign o_load  = load_q;

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_idx))); // R8

  AST_LEFTOVER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_ready && i_last) |=> !pend_v_q); // R4

  AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    o_load |-> o_valid); // R7

endmodule

// File: rtl/tree_lut_accum.sv
module tree_lut_accum
  import tla_pkg::*;
#(
  parameter int N_TERMS = 8,
  parameter int W_IN    = 3,
  parameter int W_GROW  = 1,
  localparam int LEVELS = lvl_count(N_TERMS),
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int W_OUT  = lvl_width(W_IN, W_GROW, LEVELS),
  localparam int AW_MAX = 2 * lvl_width(W_IN, W_GROW, LEVELS - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [LVL_W-1:0]  tbl_level,
  input  logic [AW_MAX-1:0] tbl_addr,
  input  logic [W_OUT-1:0]  tbl_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [W_IN-1:0]   in_idx,
  input  logic              in_last,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [W_OUT-1:0]  res_idx,
  output logic              done
);
  logic eff_last;

  tla_burst #(.N_TERMS(N_TERMS)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (in_valid && in_ready),
    .in_last  (in_last),
    .eff_last (eff_last)
  );

  for (genvar g = 0; g < LEVELS; g++) begin : lvl
    localparam int WI = lvl_width(W_IN, W_GROW, g);
    localparam int WO = lvl_width(W_IN, W_GROW, g + 1);

    logic          i_valid, i_ready, i_last;
    logic [WI-1:0] i_idx;
    logic          o_valid, o_ready, o_last, o_load;
    logic [WO-1:0] o_idx;

    if (g == 0) begin : src
      assign i_valid = in_valid;
      assign i_idx   = in_idx;
      assign i_last  = eff_last;
    end else begin : src
      assign i_valid = lvl[g-1].o_valid;
      assign i_idx   = lvl[g-1].o_idx;
      assign i_last  = lvl[g-1].o_last;
    end

    if (g == LEVELS - 1) begin : snk
      assign o_ready = res_ready;
    end else begin : snk
      assign o_ready = lvl[g+1].i_ready;
    end

    tla_stage #(.WI(WI), .WO(WO)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .tbl_we   (tbl_we && (tbl_level == LVL_W'(g))),
      .tbl_addr (tbl_addr[2*WI-1:0]),
      .tbl_data (tbl_data[WO-1:0]),
      .i_valid  (i_valid),
      .i_ready  (i_ready),
      .i_idx    (i_idx),
      .i_last   (i_last),
      .o_valid  (o_valid),
      .o_ready  (o_ready),
      .o_idx    (o_idx),
      .o_last   (o_last),
      .o_load   (o_load)
    );
  end

  assign in_ready  = lvl[0].i_ready;
  assign res_valid = lvl[LEVELS-1].o_valid;
  assign res_idx   = lvl[LEVELS-1].o_idx;
  assign done      = lvl[LEVELS-1].o_load;

  AST_ROOT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> lvl[LEVELS-1].o_last); // R6

  AST_DONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_valid); // R7

  AST_READY_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |-> in_ready); // R9

endmodule

// File: tb/tree_lut_accum_test.sv
module tree_lut_accum_test;
  localparam int N      = 8;
  localparam int W_IN   = 3;
  localparam int W_GROW = 1;
  localparam int LEVELS = 3;
  localparam int W_OUT  = W_IN + LEVELS * W_GROW;
  localparam int AW_MAX = 2 * (W_IN + (LEVELS - 1) * W_GROW);

  logic clk = 0, rst_n = 0;
  logic tbl_we = 0;
  logic [1:0] tbl_level = 0;
  logic [AW_MAX-1:0] tbl_addr = 0;
  logic [W_OUT-1:0] tbl_data = 0;
  logic in_valid = 0, in_last = 0, res_ready = 1;
  logic [W_IN-1:0] in_idx = 0;
  logic in_ready, res_valid, done;
  logic [W_OUT-1:0] res_idx;

  int checks = 0, errors = 0;
  int tab [LEVELS][1024];
  int exp_q[$];
  int cur[$];
  int got_cnt = 0, done_cnt = 0, burst_cnt = 0;
  bit bp_mode = 0;
  bit mon_on = 0;
  bit prev_stall = 0;
  logic [W_OUT-1:0] prev_idx;

  always #5 clk = ~clk;

  tree_lut_accum uut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_level(tbl_level),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data), .in_valid(in_valid),
    .in_ready(in_ready), .in_idx(in_idx), .in_last(in_last),
    .res_valid(res_valid), .res_ready(res_ready), .res_idx(res_idx), .done(done)
  );

  function automatic int wid(int k); return W_IN + k * W_GROW; endfunction

  function automatic int entry(int k, int a, int b);
    if (b == 0) return a;
    return (a * 5 + b * 3 + k * 7 + 1) % (1 << wid(k + 1));
  endfunction

  function automatic int reduce(int terms[$]);
    int q[$];
    q = terms;
    for (int k = 0; k < LEVELS; k++) begin
      int nq[$];
      for (int i = 0; i < q.size(); i += 2) begin
        int b;
        b = (i + 1 < q.size()) ? q[i+1] : 0;
        nq.push_back(tab[k][q[i] * (1 << wid(k)) + b]);
      end
      q = nq;
    end
    return q[0];
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic write_entry(int k, int addr, int val);
    @(negedge clk);
    tbl_we = 1; tbl_level = 2'(k); tbl_addr = AW_MAX'(addr); tbl_data = W_OUT'(val);
    tab[k][addr] = val;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic load_tables();
    for (int k = 0; k < LEVELS; k++)
      for (int addr = 0; addr < (1 << (2 * wid(k))); addr++) begin
        @(negedge clk);
        tbl_we = 1; tbl_level = 2'(k); tbl_addr = AW_MAX'(addr);
        tab[k][addr] = entry(k, addr >> wid(k), addr & ((1 << wid(k)) - 1));
        tbl_data = W_OUT'(tab[k][addr]);
      end
    @(negedge clk);
    tbl_we = 0;
  endtask

  // Sends one term, waiting until it is taken; models burst closure (R5).
  task automatic send(int idx, bit last);
    bit acc;
    acc = 0;
    while (!acc) begin
      @(negedge clk);
      in_valid = 1; in_idx = W_IN'(idx); in_last = last;
      #1;
      acc = in_ready;
    end
    cur.push_back(idx);
    if (last || cur.size() == N) begin
      exp_q.push_back(reduce(cur));
      cur.delete();
      burst_cnt++;
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic send_list(int vals[$], bit mark_last);
    for (int i = 0; i < vals.size(); i++)
      send(vals[i], mark_last && (i == vals.size() - 1));
  endtask

  task automatic send_rand(int len);
    for (int i = 0; i < len; i++)
      send($urandom % (1 << W_IN), i == len - 1);
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R6 pending results", exp_q.size(), 0);
  endtask

  always @(negedge clk) res_ready <= bp_mode ? 1'($urandom % 2) : 1'b1;

  // Per-clock comparison against the reference queue.
  always @(negedge clk) begin
    #2;
    if (mon_on) begin
      if (prev_stall) begin
        chk(res_valid === 1'b1, "R8 valid held", res_valid, 1);
        chk(res_idx === prev_idx, "R8 index held", res_idx, prev_idx);
      end
      if (done) begin
        done_cnt++;
        chk(res_valid === 1'b1, "R7 done with valid", res_valid, 1);
      end
      if (res_ready) chk(in_ready === 1'b1, "R9 ready flows", in_ready, 1);
      if (res_valid && res_ready) begin
        got_cnt++;
        if (exp_q.size() == 0) chk(0, "R6 unexpected result", res_idx, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(res_idx == W_OUT'(e), "R3/R6 root value", res_idx, e);
        end
      end
      prev_stall = res_valid && !res_ready;
      prev_idx   = res_idx;
    end
  end

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v[$];
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(res_valid === 1'b0, "R1 res_valid", res_valid, 0);
    chk(done === 1'b0, "R1 done", done, 0);
    chk(in_ready === 1'b1, "R1 in_ready", in_ready, 1);
    load_tables();
    mon_on = 1;

    // R3: full burst, fixed pattern
    v = '{1, 2, 3, 4, 5, 6, 7, 1}; send_list(v, 1); drain();
    // R4: odd lengths exercise leftovers at several levels
    v = '{3, 6, 2, 7, 5}; send_list(v, 1); drain();
    v = '{5}; send_list(v, 1); drain();
    v = '{7, 1, 4}; send_list(v, 1); drain();
    v = '{2, 2, 2, 2, 2, 2, 3}; send_list(v, 1); drain();
    // R5: ten terms with in_last only on the tenth -> bursts of 8 and 2
    v = '{1, 3, 5, 7, 2, 4, 6, 1, 6, 3}; send_list(v, 1); drain();
    // R2: rewrite level-0 entry {2,5}, then read it
    write_entry(0, (2 << W_IN) | 5, 13);
    v = '{2, 5}; send_list(v, 1); drain();
    // R8: random back-pressure with back-to-back random bursts
    bp_mode = 1;
    for (int b = 0; b < 40; b++) send_rand(1 + ($urandom % N));
    drain();
    bp_mode = 0;
    repeat (4) @(negedge clk);
    chk(got_cnt == burst_cnt, "R6 one result per burst", got_cnt, burst_cnt);
    chk(done_cnt == burst_cnt, "R7 one done per burst", done_cnt, burst_cnt);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule